// File: doc/BRIEF.md
# Serial-Bus Real-Time-Clock Register Slave

This block is the digital core of a real-time-clock device reached over a four-wire serial bus: an active-low select, a serial clock, a host-to-device data line and a device-to-host data line. Every access is a 64-bit frame. The host first shifts in a 32-bit command word whose top bit selects write (1) or read (0) and whose lower 31 bits name a register offset. It then exchanges one 32-bit data word: for a write the host shifts the word in, and for a read the device shifts the register contents out. All serial lines are brought into the system clock domain through two-stage synchronizers and edge-detected there.

Behind the serial engine sits a register file. It holds a seconds counter with a snapshot copy, an on-alarm and an off-alarm timer that each have a compare value, a sticky detect flag and an enable, a status word with a fixed revision code and two power-event flags, an enables word, four scratch words and sixteen SRAM bank words. Time comes in as a half-second strobe `tick_i`. The block turns it into a 1 Hz square wave and into one counter increment per second.

Top module: `rtc_serial_slave`

## Requirements
- R1: While `csn_i` is low, `mosi_i` is sampled on each rising serial clock edge, most significant bit first. The first 32 bits form the command: bit 31 = 1 means write, 0 means read, and bits 30..0 are the offset. The next 32 bits form the data phase.
- R2: For a write, the 32 data bits are stored in the addressed register after the 64th rising edge. For a read, the register value appears on `miso_o` MSB first, and each bit is driven on a falling serial clock edge. The first bit is driven on the falling edge that follows the 32nd rising edge.
- R3: The seconds counter (offset 0x20000000) advances by one on every second `tick_i` strobe: the 2nd, 4th, 6th and so on after reset. A write to it loads the written value.
- R4: `sq_o` is 0 after reset and toggles on every `tick_i` strobe, which gives a 1 Hz square wave.
- R5: Decoding a read command for the counter offset copies the counter into the snapshot register (offset 0x20400000). Reading the snapshot register returns the last captured value.
- R6: The sixteen SRAM bank words (offset 0x20000100 + k*0x100, k = 0..15), the four scratch words (0x21001000 + j*0x100, j = 0..3) and the enables word (0x21000D00) are plain 32-bit read/write registers.
- R7: The on-timer (0x21000000) and the off-timer (0x21000100) each hold a compare value in bits 29..0, a detect flag in bit 30 and an enable in bit 31. When the counter advances to a value whose low 30 bits equal the compare value and the enable is set, the detect flag is set. The flag stays set until a write carries 0 in bit 30. A write with 1 in bit 30 cannot set the flag.
- R8: The status word (0x21000C00) reads the fixed revision 0x3C in bits 7..0, the on-timer event in bit 16, the off-timer event in bit 24, and 0 in all other bits. Each event flag is set together with its timer's detect flag. It is cleared by writing 0 to its bit. The revision bits ignore writes.
- R9: A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.
- R10: Raising `csn_i` before a frame is complete aborts it. No write takes place, and the next frame starts again with a command phase.
- R11: After reset, the counter, the snapshot, the timers, the event flags and all storage words read 0, and `miso_o` and `sq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Half-second strobe, one system clock wide |
| sclk_i | input | 1 | Serial bus clock |
| csn_i | input | 1 | Serial bus select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| sq_o | output | 1 | 1 Hz square-wave output |

## Verification
Serial edges reach the logic two system cycles after the pins change and are registered one cycle later. A read word's first bit is therefore on `miso_o` three system cycles after the falling serial edge, and a write commits four system cycles after the 64th rising edge. The bench holds each serial half-period for eight system cycles and samples `miso_o` at the end of the low phase, just before it raises the clock. It leaves at least eight idle cycles after every frame before it compares register contents. Tick effects are due one cycle after the strobe, and the bench reads them back only after two more cycles.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
    localparam int WORD_W = 32;
    localparam int OFS_W  = WORD_W - 1;

    localparam logic [OFS_W-1:0] OFS_COUNT = 31'h2000_0000;
    localparam logic [OFS_W-1:0] OFS_SRAM0 = 31'h2000_0100;
    localparam logic [OFS_W-1:0] OFS_SNAP  = 31'h2040_0000;
    localparam logic [OFS_W-1:0] OFS_ONT   = 31'h2100_0000;
    localparam logic [OFS_W-1:0] OFS_OFFT  = 31'h2100_0100;
    localparam logic [OFS_W-1:0] OFS_STAT  = 31'h2100_0C00;
    localparam logic [OFS_W-1:0] OFS_ENA   = 31'h2100_0D00;
    localparam logic [OFS_W-1:0] OFS_SCR0  = 31'h2100_1000;
    localparam int               OFS_STEP  = 256;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_COUNT, SEL_SNAP, SEL_SRAM, SEL_ONT,
        SEL_OFFT, SEL_STAT, SEL_ENA, SEL_SCR
    } sel_e;
endpackage

// File: rtl/rtcs_link.sv
module rtcs_link
    import rtcs_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                csn_i,
    input  logic                mosi_i,
    output logic                miso_o,
    output logic [OFS_W-1:0]    addr_o,
    output logic                rd_en_o,
    output logic                wr_en_o,
    output logic [WORD_W-1:0]   wdata_o,
    input  logic [WORD_W-1:0]   rdata_i
);
    localparam int FRAME = 2 * WORD_W;
    localparam int CNT_W = $clog2(FRAME);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(WORD_W);

    typedef struct packed {
        logic [SYNC_N:0]   sclk;
        logic [SYNC_N-1:0] csn;
        logic [SYNC_N-1:0] mosi;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] tx;
        logic              miso;
        logic              rd_en;
        logic              wr_en;
        logic [WORD_W-1:0] wdata;
    } link_t;

    link_t q, d;
    logic  rise, fall, csn_s, mosi_s;

    always_comb begin
        d       = q;
        d.rd_en = 1'b0;
        d.wr_en = 1'b0;
        d.sclk  = {q.sclk[SYNC_N-1:0], sclk_i};
        d.csn   = {q.csn[SYNC_N-2:0], csn_i};
        d.mosi  = {q.mosi[SYNC_N-2:0], mosi_i};
        rise    = q.sclk[SYNC_N-1] & ~q.sclk[SYNC_N];
        fall    = ~q.sclk[SYNC_N-1] & q.sclk[SYNC_N];
        csn_s   = q.csn[SYNC_N-1];
        mosi_s  = q.mosi[SYNC_N-1];
        if (csn_s) begin
            d.cnt  = '0;
            d.miso = 1'b0;
            d.tx   = '0;
        end else begin
            if (rise) begin
                d.sh  = {q.sh[WORD_W-2:0], mosi_s};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CMD_LAST) begin
                    d.cmd   = {q.sh[WORD_W-2:0], mosi_s};
                    d.rd_en = ~q.sh[WORD_W-2];
                    d.tx    = '0;
                end
                if (q.cnt == DATA_LAST) begin
                    d.wr_en = q.cmd[WORD_W-1];
                    d.wdata = {q.sh[WORD_W-2:0], mosi_s};
                end
            end
            if (fall && q.cnt >= DATA_FIRST) begin
                d.miso = q.tx[WORD_W-1];
                d.tx   = {q.tx[WORD_W-2:0], 1'b0};
            end
            if (q.rd_en) begin
                d.tx = rdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.csn  <= '1;
        end else begin
            q <= d;
        end
    end

    assign miso_o  = q.miso;
    assign addr_o  = q.cmd[OFS_W-1:0];
    assign rd_en_o = q.rd_en;
    assign wr_en_o = q.wr_en;
    assign wdata_o = q.wdata;

    assert_rw_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.rd_en, q.wr_en}));
    assert_wr_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> q.cmd[WORD_W-1]);
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.csn[SYNC_N-1] |=> (q.cnt == '0 && !q.miso));
endmodule

// File: rtl/rtcs_regs.sv
module rtcs_regs
    import rtcs_pkg::*;
#(
    parameter int         N_SRAM = 16,
    parameter int         N_SCR  = 4,
    parameter int         TMR_W  = 30,
    parameter logic [7:0] REV    = 8'h3C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [OFS_W-1:0]   addr_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               sq_o
);
    localparam int SRAM_IW = $clog2(N_SRAM);
    localparam int SCR_IW  = $clog2(N_SCR);
    localparam int DET_B   = TMR_W;
    localparam int EN_B    = TMR_W + 1;
    localparam int EVON_B  = 16;
    localparam int EVOFF_B = 24;

    typedef struct packed {
        logic [WORD_W-1:0]             count;
        logic                          half;
        logic [WORD_W-1:0]             snap;
        logic [WORD_W-1:0]             ont;
        logic [WORD_W-1:0]             offt;
        logic                          ev_on;
        logic                          ev_off;
        logic [WORD_W-1:0]             ena;
        logic [N_SCR-1:0][WORD_W-1:0]  scr;
        logic [N_SRAM-1:0][WORD_W-1:0] sram;
    } regs_t;

    regs_t              q, d;
    sel_e               sel;
    logic [SRAM_IW-1:0] sram_idx;
    logic [SCR_IW-1:0]  scr_idx;
    logic               adv, wr_count;

    // offset decode
    always_comb begin
        sel      = SEL_NONE;
        sram_idx = '0;
        scr_idx  = '0;
        if (addr_i == OFS_COUNT) sel = SEL_COUNT;
        if (addr_i == OFS_SNAP)  sel = SEL_SNAP;
        if (addr_i == OFS_ONT)   sel = SEL_ONT;
        if (addr_i == OFS_OFFT)  sel = SEL_OFFT;
        if (addr_i == OFS_STAT)  sel = SEL_STAT;
        if (addr_i == OFS_ENA)   sel = SEL_ENA;
        for (int k = 0; k < N_SRAM; k++) begin
            if (addr_i == OFS_SRAM0 + OFS_W'(k * OFS_STEP)) begin
                sel      = SEL_SRAM;
                sram_idx = SRAM_IW'(k);
            end
        end
        for (int j = 0; j < N_SCR; j++) begin
            if (addr_i == OFS_SCR0 + OFS_W'(j * OFS_STEP)) begin
                sel     = SEL_SCR;
                scr_idx = SCR_IW'(j);
            end
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_COUNT: rdata_o = q.count;
            SEL_SNAP:  rdata_o = q.snap;
            SEL_ONT:   rdata_o = q.ont;
            SEL_OFFT:  rdata_o = q.offt;
            SEL_ENA:   rdata_o = q.ena;
            SEL_SRAM:  rdata_o = q.sram[sram_idx];
            SEL_SCR:   rdata_o = q.scr[scr_idx];
            SEL_STAT: begin
                rdata_o[7:0]     = REV;
                rdata_o[EVON_B]  = q.ev_on;
                rdata_o[EVOFF_B] = q.ev_off;
            end
            default:   rdata_o = '0;
        endcase
    end

    // next state
    always_comb begin
        d        = q;
        adv      = tick_i & q.half;
        wr_count = wr_en_i && (sel == SEL_COUNT);
        if (tick_i) d.half = ~q.half;
        if (adv)    d.count = q.count + 1'b1;
        if (rd_en_i && sel == SEL_COUNT) d.snap = q.count;
        if (wr_en_i) begin
            case (sel)
                SEL_COUNT: d.count = wdata_i;
                SEL_ENA:   d.ena   = wdata_i;
                SEL_SRAM:  d.sram[sram_idx] = wdata_i;
                SEL_SCR:   d.scr[scr_idx]   = wdata_i;
                SEL_ONT: begin
                    d.ont        = wdata_i;
                    d.ont[DET_B] = q.ont[DET_B] & wdata_i[DET_B];
                end
                SEL_OFFT: begin
                    d.offt        = wdata_i;
                    d.offt[DET_B] = q.offt[DET_B] & wdata_i[DET_B];
                end
                SEL_STAT: begin
                    d.ev_on  = q.ev_on  & wdata_i[EVON_B];
                    d.ev_off = q.ev_off & wdata_i[EVOFF_B];
                end
                default: ;
            endcase
        end
        if (adv && !wr_count) begin
            if (d.ont[EN_B] && d.count[TMR_W-1:0] == d.ont[TMR_W-1:0]) begin
                d.ont[DET_B] = 1'b1;
                d.ev_on      = 1'b1;
            end
            if (d.offt[EN_B] && d.count[TMR_W-1:0] == d.offt[TMR_W-1:0]) begin
                d.offt[DET_B] = 1'b1;
                d.ev_off      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sq_o = q.half;

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_count) |=> q.count == $past(q.count) + 1'b1);
    assert_sq_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> sq_o != $past(sq_o));
    assert_snap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel == SEL_COUNT) |=> q.snap == $past(q.count));
    assert_det_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ont[DET_B] && !(wr_en_i && sel == SEL_ONT)) |=> q.ont[DET_B]);
    assert_ev_with_det_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.offt[DET_B]) |-> q.ev_off);
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtcs_pkg::*;
#(
    parameter int         N_SRAM = 16,
    parameter int         N_SCR  = 4,
    parameter int         TMR_W  = 30,
    parameter logic [7:0] REV    = 8'h3C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic sq_o
);
    logic [OFS_W-1:0]  addr;
    logic              rd_en, wr_en;
    logic [WORD_W-1:0] wdata, rdata;

    rtcs_link #(.SYNC_N(2)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .csn_i   (csn_i),
        .mosi_i  (mosi_i),
        .miso_o  (miso_o),
        .addr_o  (addr),
        .rd_en_o (rd_en),
        .wr_en_o (wr_en),
        .wdata_o (wdata),
        .rdata_i (rdata)
    );

    rtcs_regs #(
        .N_SRAM (N_SRAM),
        .N_SCR  (N_SCR),
        .TMR_W  (TMR_W),
        .REV    (REV)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .addr_i  (addr),
        .rd_en_i (rd_en),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .sq_o    (sq_o)
    );
endmodule

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;
    logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, sq;
    int   n_chk = 0, n_bad = 0, n_strobe = 0;
    bit   finished = 1'b0;

    localparam int HP = 8;
    localparam logic [30:0] A_CNT  = 31'h2000_0000;
    localparam logic [30:0] A_SNAP = 31'h2040_0000;
    localparam logic [30:0] A_B0   = 31'h2000_0100;
    localparam logic [30:0] A_B5   = 31'h2000_0600;
    localparam logic [30:0] A_B15  = 31'h2000_1000;
    localparam logic [30:0] A_ONT  = 31'h2100_0000;
    localparam logic [30:0] A_OFFT = 31'h2100_0100;
    localparam logic [30:0] A_STAT = 31'h2100_0C00;
    localparam logic [30:0] A_ENA  = 31'h2100_0D00;
    localparam logic [30:0] A_SCR0 = 31'h2100_1000;
    localparam logic [30:0] A_SCR3 = 31'h2100_1300;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] got_q[$];

    rtc_serial_slave uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sclk_i(sclk),
        .csn_i(csn), .mosi_i(mosi), .miso_o(miso), .sq_o(sq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] cmd, input logic [31:0] wd,
                         input int nbits, output logic [31:0] rd);
        logic [63:0] bits;
        bits = {cmd, wd};
        rd   = '0;
        csn  = 1'b0;
        cycles(HP);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = bits[63-i];
            cycles(HP);
            if (i >= 32) rd = {rd[30:0], miso};
            sclk = 1'b1;
            cycles(HP);
        end
        sclk = 1'b0;
        cycles(HP);
        csn = 1'b1;
        cycles(HP + 2);
    endtask

    task automatic wr(input logic [30:0] a, input logic [31:0] v);
        logic [31:0] dummy;
        frame({1'b1, a}, v, 64, dummy);
    endtask

    // driver side of the scoreboard: push expectation, then run the frame
    task automatic rd(input logic [30:0] a, input logic [31:0] e, input string tag);
        logic [31:0] r;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        frame({1'b0, a}, 32'h0, 64, r);
        got_q.push_back(r);
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
            n_strobe++;
            cycles(2);
        end
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] junk;
        cycles(5);
        rst_n = 1'b1;
        cycles(3);
        // R11 reset state
        check("R11 sq reset", {31'b0, sq}, 32'h0);
        check("R11 miso reset", {31'b0, miso}, 32'h0);
        rd(A_CNT,  32'h0, "R11 counter reset");
        rd(A_SNAP, 32'h0, "R11 snapshot reset");
        rd(A_B5,   32'h0, "R11 sram reset");
        rd(A_ONT,  32'h0, "R11 on-timer reset");
        rd(A_STAT, 32'h0000_003C, "R8 status revision");

        // R6 storage words, R1/R2 framing with varied patterns
        wr(A_B0,  32'hA5A5_0F0F);
        wr(A_B15, 32'h8000_0001);
        wr(A_SCR3, 32'h1234_5678);
        wr(A_ENA, 32'hFFFF_FFFF);
        rd(A_B0,  32'hA5A5_0F0F, "R6 sram bank0");
        rd(A_B15, 32'h8000_0001, "R2 msb/lsb bank15");
        rd(A_SCR3, 32'h1234_5678, "R6 scratch3");
        rd(A_ENA, 32'hFFFF_FFFF, "R1 enables word");

        // R9 unmapped
        wr(31'h2000_1100, 32'hDEAD_BEEF);
        rd(A_B15, 32'h8000_0001, "R9 neighbour untouched");
        rd(31'h2000_1100, 32'h0, "R9 unmapped read");
        rd(31'h2100_0200, 32'h0, "R9 unmapped gap");

        // R4 square wave and R3 counting
        for (int i = 0; i < 6; i++) begin
            strobe(1);
            check("R4 square wave", {31'b0, sq}, 32'(n_strobe % 2));
        end
        rd(A_CNT, 32'd3, "R3 counter after six strobes");
        wr(A_CNT, 32'd100);
        rd(A_CNT, 32'd100, "R3 counter write");
        strobe(2);
        rd(A_SNAP, 32'd100, "R5 snapshot held");
        rd(A_CNT, 32'd101, "R3 counter advance");
        rd(A_SNAP, 32'd101, "R5 snapshot reloaded");

        // R7 on-timer detect
        wr(A_ONT, 32'h8000_0067);
        strobe(4);
        rd(A_ONT, 32'hC000_0067, "R7 on-timer detect");
        rd(A_STAT, 32'h0001_003C, "R8 on event flag");
        wr(A_ONT, 32'hC000_0067);
        strobe(2);
        rd(A_ONT, 32'hC000_0067, "R7 detect sticky");
        wr(A_ONT, 32'h8000_0067);
        rd(A_ONT, 32'h8000_0067, "R7 detect cleared");
        wr(A_OFFT, 32'h4000_0005);
        rd(A_OFFT, 32'h0000_0005, "R7 write one cannot set");

        // R7 disabled timer, then enabled
        wr(A_OFFT, 32'h0000_0069);
        strobe(2);
        rd(A_OFFT, 32'h0000_0069, "R7 disabled no detect");
        rd(A_STAT, 32'h0001_003C, "R8 no off event");
        wr(A_OFFT, 32'h8000_006A);
        strobe(2);
        rd(A_OFFT, 32'hC000_006A, "R7 off-timer detect");
        rd(A_STAT, 32'h0101_003C, "R8 off event flag");
        wr(A_STAT, 32'h00FF_00FF);
        rd(A_STAT, 32'h0001_003C, "R8 clear off keep on");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h0000_003C, "R8 all cleared, rev fixed");

        // R10 abort
        wr(A_SCR0, 32'h1111_2222);
        frame({1'b1, A_SCR0}, 32'h3333_4444, 40, junk);
        rd(A_SCR0, 32'h1111_2222, "R10 aborted write");
        frame({1'b1, A_SCR0}, 32'h5555_6666, 20, junk);
        rd(A_SCR0, 32'h1111_2222, "R10 resync after abort");

        cycles(20);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule